// File: doc/BRIEF.md
# Multiphase Fractional Divider Controller

This block is the control logic of a fractional-N feedback divider that works with an oscillator delivering eight equally spaced phases. It runs on the currently selected phase clock and counts a period of N cycles. During the first F cycles of each period it raises an advance strobe. Each advance cycle moves a Gray-coded phase select one position forward, so the external phase multiplexer switches to the phase just ahead of the present one. Every step removes one eighth of a cycle from the period, so over a period of N counted cycles the divided output averages N − F/8 input cycles. With N = 8 and F = 3, for example, the ratio is 7.625.

The integer count and the fraction are plain control inputs. They are captured only at the boundary between periods, so a period already under way always runs out with the settings it began with. The integer count is clamped to the supported range of 7 to 16. At the lowest count the fraction is dropped, which keeps the ratio from falling below 7. The divided clock is produced from the period count and is high for the first half of each period.

Top module: `frac_div_ctrl`

## Requirements
- R1: While rst_n is low, phase_sel is 000, advance is 0 and div_clk is 1. The active settings are N = 7 and F = 0, and the first period after reset uses them.
- R2: The period count runs 0, 1, …, N−1 and then returns to 0, one step per clock. div_clk is 1 exactly while the count is below floor(N/2), so it has a period of N clocks.
- R3: advance is 1 exactly while the count is below F. After each clock edge at which advance was 1, phase_sel has moved one step forward in the order 000, 001, 011, 010, 110, 111, 101, 100 and wraps from 100 back to 000. Each period therefore gives F steps and an average ratio of N − F/8.
- R4: After a clock edge at which advance was 0, phase_sel is unchanged. The selection never moves backward.
- R5: With F = 0, phase_sel never changes, and the block divides by the integer N alone.
- R6: div_int and div_frac are sampled only at the clock edge that ends a period, when the count is N−1. They take effect from the next period. A change made at any other time has no effect on the period under way.
- R7: An N sample below 7 is used as 7. An N sample above 16 is used as 16.
- R8: When the N in use is 7, the fraction in use is 0 whatever div_frac holds.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Currently selected oscillator phase, which clocks the block |
| rst_n | input | 1 | Active-low synchronous reset |
| div_int | input | 5 | Requested integer division count N |
| div_frac | input | 3 | Requested fraction F, in eighths of a cycle |
| phase_sel | output | 3 | Gray-coded phase select for the external 8-to-1 multiplexer |
| advance | output | 1 | High during the cycles that step the phase select |
| div_clk | output | 1 | Divided clock, high for the first half of each period |

## Verification
The bench targets five corner cases.

- **Gray wrap.** The bench holds N = 16 with F = 7 across many periods, so the select wraps from 100 back to 000 repeatedly. A design with a wrong wrap or a wrong Gray order would drive a code that is not the next phase, and the multiplexer would glitch.
- **Clamp edges.** The bench drives N requests of 3, 0 and 31. A design that skipped the clamp would shorten or stretch the period outside the supported range.
- **Lowest count with a fraction.** The bench sets N = 7 with a nonzero F. A design that kept the fraction here would give a ratio below 7.
- **Settings changed mid-period.** Random stimulus changes both settings at arbitrary cycles. A design that did not hold its settings to the period boundary would cut a period short, or give the wrong number of steps in it.
- **Zero fraction.** With F = 0, a phase step would be a spurious phase change.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 5;
  localparam int PHASES = 1 << SEL_W;

  typedef struct packed {
    logic [CNT_W-1:0] n;
    logic [SEL_W-1:0] f;
  } cfg_t;

  function automatic logic [SEL_W-1:0] gray2bin(input logic [SEL_W-1:0] g);
    logic [SEL_W-1:0] b;
    b[SEL_W-1] = g[SEL_W-1];
    for (int i = SEL_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fdc_cfg_latch.sv
module fdc_cfg_latch
  import fdc_pkg::*;
#(
  parameter int N_MIN = 7,
  parameter int N_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] req_n,
  input  logic [SEL_W-1:0] req_f,
  output cfg_t             cfg
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(N_MIN);
  localparam logic [CNT_W-1:0] HI = CNT_W'(N_MAX);

  logic [CNT_W-1:0] n_cl;
  logic [SEL_W-1:0] f_cl;

  always_comb begin
    if (req_n < LO)      n_cl = LO;
    else if (req_n > HI) n_cl = HI;
    else                 n_cl = req_n;
    f_cl = (n_cl == LO) ? '0 : req_f;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.n <= LO;
      cfg.f <= '0;
    end else if (load) begin
      cfg.n <= n_cl;
      cfg.f <= f_cl;
    end
  end
endmodule

// File: rtl/fdc_period_cnt.sv
module fdc_period_cnt
  import fdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             adv,
  output logic             dclk
);
  logic [CNT_W-1:0] f_ext;
  logic [CNT_W-1:0] half;

  always_comb begin
    f_ext = {{(CNT_W-SEL_W){1'b0}}, cfg.f};
    half  = cfg.n >> 1;
    last  = (cnt == cfg.n - CNT_W'(1));
    adv   = (cnt < f_ext);
    dclk  = (cnt < half);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (last)  cnt <= '0;
    else            cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/fdc_gray_step.sv
module fdc_gray_step
  import fdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [SEL_W-1:0] sel
);
  logic [SEL_W-1:0] bin_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    bin_q <= '0;
    else if (step) bin_q <= bin_q + SEL_W'(1);
  end

  assign sel[SEL_W-1] = bin_q[SEL_W-1];
  for (genvar i = 0; i < SEL_W - 1; i++) begin : g_gray
    assign sel[i] = bin_q[i] ^ bin_q[i+1];
  end
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
  import fdc_pkg::*;
#(
  parameter int N_MIN = 7,
  parameter int N_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_int,
  input  logic [SEL_W-1:0] div_frac,
  output logic [SEL_W-1:0] phase_sel,
  output logic             advance,
  output logic             div_clk
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  fdc_cfg_latch #(.N_MIN(N_MIN), .N_MAX(N_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(wrap),
    .req_n(div_int), .req_f(div_frac), .cfg(cfg_q)
  );

  fdc_period_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .cnt(cnt_q), .last(wrap), .adv(advance), .dclk(div_clk)
  );

  fdc_gray_step u_gray (
    .clk(clk), .rst_n(rst_n), .step(advance), .sel(phase_sel)
  );
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker
  import fdc_pkg::*;
#(
  parameter int N_MIN = 7,
  parameter int N_MAX = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel,
  input logic             adv,
  input logic             dclk,
  input logic [CNT_W-1:0] cnt,
  input cfg_t             cfg
);
  a_r3_forward_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> gray2bin(sel) == SEL_W'(gray2bin($past(sel)) + SEL_W'(1)));

  a_r4_hold_select: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(sel));

  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cfg.n);

  a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> cnt == '0);

  a_r6_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(cfg));

  a_r7_n_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.n >= CNT_W'(N_MIN) && cfg.n <= CNT_W'(N_MAX));

  a_r8_no_frac_at_min: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.n == CNT_W'(N_MIN)) |-> !adv);
endmodule

bind frac_div_ctrl fdc_checker #(.N_MIN(N_MIN), .N_MAX(N_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(phase_sel), .adv(advance),
  .dclk(div_clk), .cnt(cnt_q), .cfg(cfg_q)
);

// File: tb/frac_div_ctrl_bench.sv
`timescale 1ns/1ps
module frac_div_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] div_int = 5'd8;
  logic [2:0] div_frac = 3'd0;
  logic [2:0] phase_sel;
  logic       advance;
  logic       div_clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  int m_cnt = 0, m_n = 7, m_f = 0, m_bin = 0;

  frac_div_ctrl u_frac_div_ctrl (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
    .phase_sel(phase_sel), .advance(advance), .div_clk(div_clk)
  );

  always #2.5 clk = ~clk;

  function automatic int gray_of(int b);
    return (b ^ (b >> 1)) & 7;
  endfunction

  function automatic int clamp_n(int n);
    if (n < 7)  return 7;
    if (n > 16) return 16;
    return n;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int e_sel, e_adv, e_clk;
    e_sel = rst_n ? gray_of(m_bin) : 0;
    e_adv = (rst_n && m_cnt < m_f) ? 1 : 0;
    e_clk = (m_cnt < m_n / 2) ? 1 : 0;
    check(int'(phase_sel) == e_sel, tag, "phase_sel", int'(phase_sel), e_sel);
    check(int'(advance) == e_adv, tag, "advance", int'(advance), e_adv);
    check(int'(div_clk) == e_clk, tag, "div_clk", int'(div_clk), e_clk);
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_cnt = 0; m_n = 7; m_f = 0; m_bin = 0;
      return;
    end
    if (m_cnt < m_f) m_bin = (m_bin + 1) % 8;
    if (m_cnt == m_n - 1) begin
      m_cnt = 0;
      m_n = clamp_n(int'(div_int));
      m_f = (m_n == 7) ? 0 : int'(div_frac);
    end else begin
      m_cnt++;
    end
  endtask

  task automatic run(int cycles, string tag, int n, int f);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare(tag);
      if (i == 0) begin
        div_int = 5'(n);
        div_frac = 3'(f);
      end
      model_step();
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    run(4, "R1", 8, 3);
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    model_step();
    run(60, "R3", 8, 3);
    run(60, "R5", 10, 0);
    run(40, "R7", 3, 4);
    run(40, "R7", 0, 6);
    run(60, "R7", 31, 5);
    run(40, "R8", 7, 5);
    run(40, "R2", 9, 0);
    run(200, "R3", 16, 7);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      compare("R6");
      if ($urandom_range(0, 9) == 0) begin
        div_int = 5'($urandom_range(0, 31));
        div_frac = 3'($urandom_range(0, 7));
      end
      model_step();
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule